// File: doc/BRIEF.md
# Odd-Parity Asynchronous Serial Port

This block is a full-duplex asynchronous serial port for an 8-bit controller. A write strobe hands a byte to the transmitter. The transmitter sends one framed character on the serial output. The receiver watches the serial input, rebuilds each character and presents the byte together with a framing status. Both halves take their timing from one external tick. The tick runs at sixteen times the bit rate and comes from a counter/timer outside the block, so no divider sits inside the port.

Odd-parity mode is chosen with a level input and keeps the character width at eight bits. On transmit, the top bit of the written byte is dropped and the odd-parity bit over the seven low bits goes in its slot. On receive, the top bit of the delivered byte becomes a parity-error flag. Each finished transmit character raises a one-cycle interrupt pulse, and so does each finished receive character.

Top module: `sio_core`

## Requirements
- R1: After reset `txd` is high, `tx_busy`, `tx_irq`, `rx_irq` and `rx_ferr` are 0, and `rx_data` is 0x00.
- R2: A transmitted character is a low start bit, then eight data slots sent least-significant bit first, then two high stop bits. Each slot lasts 16 ticks of `bit_tick`.
- R3: With `parity_en` = 1 when the byte is written, data slot 7 carries the odd-parity bit over bits 6..0 of the byte, so all eight data slots together hold an odd number of ones. Bit 7 of the byte is discarded. With `parity_en` = 0, slot 7 carries bit 7 of the byte.
- R4: `tx_busy` is high from the cycle after an accepted write until the 176th tick after it. On that tick `tx_busy` falls and `tx_irq` is high for exactly one cycle.
- R5: A write while `tx_busy` is high is ignored. The character in flight is unchanged, and no extra character or `tx_irq` follows it.
- R6: The receiver accepts a low start bit confirmed at mid-bit. It samples eight data bits, least-significant first, at their centres, presents the byte on `rx_data` and pulses `rx_irq` for one cycle per character. `rx_data` and `rx_ferr` change only in the cycle `rx_irq` is high.
- R7: A single stop bit is enough. Two characters sent back to back with one stop bit each are both received correctly.
- R8: With `parity_en` = 1, `rx_data[7]` is 1 when the eight received data bits hold an even number of ones and 0 when they hold an odd number. `rx_data[6:0]` are the received bits 6..0.
- R9: When the stop-bit sample is low, `rx_ferr` is set, the byte is still delivered and `rx_irq` still pulses. The next character with a good stop bit clears `rx_ferr`.
- R10: A low pulse on `rxd` that ends before mid-bit (shorter than 8 ticks) is not taken as a start bit and raises no `rx_irq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bit_tick | input | 1 | One-cycle pulse at 16x the bit rate, from the external counter/timer |
| parity_en | input | 1 | 1 selects odd-parity mode |
| tx_data | input | 8 | Byte to transmit |
| tx_wr | input | 1 | Write strobe for `tx_data` |
| txd | output | 1 | Serial output, idles high |
| tx_busy | output | 1 | A character is being shifted out |
| tx_irq | output | 1 | One-cycle pulse when a character is finished |
| rxd | input | 1 | Serial input, asynchronous |
| rx_data | output | 8 | Last received byte, with the parity flag in bit 7 in parity mode |
| rx_ferr | output | 1 | Stop-bit sample of the last character was low |
| rx_irq | output | 1 | One-cycle pulse when a received character is presented |

## Verification
A bad transmit shift register or slot counter shows up on `txd` within one bit time of the bad state, as a wrong slot value at a mid-slot sample. If the frame length drifts, `tx_irq` lands on the wrong tick. A bad receive state shows at the next `rx_irq`: the byte is wrong, the interrupt is missing or doubled, or the status is wrong. That happens at most one character time later. The bench loops the transmitter into the receiver for every byte value in both parity modes, drives the receiver directly to sweep the parity flag, and builds framing-error, single-stop and glitch patterns by hand.

// File: rtl/sio_pkg.sv
// Package: shared types for the serial port.
// Assumes: all blocks use the same oversampling tick.
package sio_pkg;
    // Receiver sequencing states.
    typedef enum logic [2:0] {
        RX_IDLE  = 3'd0,
        RX_START = 3'd1,
        RX_DATA  = 3'd2,
        RX_STOP  = 3'd3,
        RX_WAIT  = 3'd4
    } rx_state_t;
endpackage

// File: rtl/sio_sync.sv
// Module: sio_sync
// Brings an asynchronous input into the clock domain through a flop chain.
// Assumes: the input idles high, so the chain resets to 1.
module sio_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_async,
    output logic d_sync
);
    logic [STAGES-1:0] chain;

    // Shift the raw input through the chain.
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= '1;
        else        chain <= {chain[STAGES-2:0], d_async};
    end

    assign d_sync = chain[STAGES-1];
endmodule

// File: rtl/sio_tx.sv
// Module: sio_tx
// Serialises one byte per accepted write: start bit, DW data slots LSB first,
// STOP_BITS stop bits. In parity mode the top slot is the odd-parity bit.
// Assumes: tick is a one-cycle pulse at OVS times the bit rate.
module sio_tx #(
    parameter int DW        = 8,
    parameter int OVS       = 16,
    parameter int STOP_BITS = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          parity_en,
    input  logic [DW-1:0] wr_data,
    input  logic          wr,
    output logic          txd,
    output logic          busy,
    output logic          irq
);
    localparam int FRAME = 1 + DW + STOP_BITS;
    localparam int CW    = $clog2(OVS);
    localparam int BW    = $clog2(FRAME + 1);

    logic [FRAME-1:0] shreg;
    logic [CW-1:0]    tcnt;
    logic [BW-1:0]    bcnt;
    logic [DW-1:0]    payload;

    // Choose the data slots: in parity mode the top bit is replaced.
    always_comb begin
        payload = wr_data;
        if (parity_en) payload[DW-1] = ~(^wr_data[DW-2:0]);
    end

    // Load on an idle write, then shift one slot every OVS ticks.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg <= '1;
            tcnt  <= '0;
            bcnt  <= '0;
            busy  <= 1'b0;
            irq   <= 1'b0;
        end else begin
            irq <= 1'b0;
            if (!busy) begin
                if (wr) begin
                    shreg <= {{STOP_BITS{1'b1}}, payload, 1'b0};
                    tcnt  <= '0;
                    bcnt  <= '0;
                    busy  <= 1'b1;
                end
            end else if (tick) begin
                if (tcnt == CW'(OVS - 1)) begin
                    tcnt  <= '0;
                    shreg <= {1'b1, shreg[FRAME-1:1]};
                    if (bcnt == BW'(FRAME - 1)) begin
                        busy <= 1'b0;
                        irq  <= 1'b1;
                    end else begin
                        bcnt <= bcnt + 1'b1;
                    end
                end else begin
                    tcnt <= tcnt + 1'b1;
                end
            end
        end
    end

    assign txd = shreg[0];

    // R2
    tx_idle_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> txd);
    // R2
    tx_start_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> !txd);
    // R4
    tx_irq_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);
    // R4
    tx_irq_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> $fell(busy));
    // R5
    tx_wr_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && wr && !tick) |=> busy);
endmodule

// File: rtl/sio_rx.sv
// Module: sio_rx
// Recovers characters from a synchronised serial line: confirms the start bit
// at mid-bit, samples DW data bits at their centres and one stop bit.
// Assumes: line already synchronised; tick at OVS times the bit rate.
module sio_rx
    import sio_pkg::*;
#(
    parameter int DW  = 8,
    parameter int OVS = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          parity_en,
    input  logic          line,
    output logic [DW-1:0] data,
    output logic          ferr,
    output logic          irq
);
    localparam int CW  = $clog2(OVS);
    localparam int BCW = $clog2(DW);

    rx_state_t      state;
    logic [CW-1:0]  tcnt;
    logic [BCW-1:0] bcnt;
    logic [DW-1:0]  shreg;
    logic [DW-1:0]  result;

    // Build the delivered byte: in parity mode the top bit is the error flag.
    always_comb begin
        result = shreg;
        if (parity_en) result[DW-1] = ~(^shreg);
    end

    // Sequence one character: hunt, confirm start, data bits, stop bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= RX_IDLE;
            tcnt  <= '0;
            bcnt  <= '0;
            shreg <= '0;
            data  <= '0;
            ferr  <= 1'b0;
            irq   <= 1'b0;
        end else begin
            irq <= 1'b0;
            unique case (state)
                RX_IDLE: begin
                    if (!line) begin
                        state <= RX_START;
                        tcnt  <= '0;
                    end
                end
                RX_START: begin
                    if (tick) begin
                        if (tcnt == CW'(OVS / 2 - 1)) begin
                            tcnt  <= '0;
                            bcnt  <= '0;
                            state <= line ? RX_IDLE : RX_DATA;
                        end else begin
                            tcnt <= tcnt + 1'b1;
                        end
                    end
                end
                RX_DATA: begin
                    if (tick) begin
                        if (tcnt == CW'(OVS - 1)) begin
                            tcnt  <= '0;
                            shreg <= {line, shreg[DW-1:1]};
                            if (bcnt == BCW'(DW - 1)) state <= RX_STOP;
                            else                      bcnt  <= bcnt + 1'b1;
                        end else begin
                            tcnt <= tcnt + 1'b1;
                        end
                    end
                end
                RX_STOP: begin
                    if (tick) begin
                        if (tcnt == CW'(OVS - 1)) begin
                            tcnt  <= '0;
                            data  <= result;
                            ferr  <= ~line;
                            irq   <= 1'b1;
                            state <= line ? RX_IDLE : RX_WAIT;
                        end else begin
                            tcnt <= tcnt + 1'b1;
                        end
                    end
                end
                RX_WAIT: begin
                    if (line) state <= RX_IDLE;
                end
                default: state <= RX_IDLE;
            endcase
        end
    end

    // R6
    rx_irq_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);
    // R6
    rx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !irq |-> ($stable(data) && $stable(ferr)));
    // R6
    rx_irq_from_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(state) == RX_STOP);
endmodule

// File: rtl/sio_core.sv
// Module: sio_core
// Full-duplex asynchronous serial port with optional odd parity.
// Assumes: bit_tick comes from an external counter/timer at 16x the bit rate.
module sio_core #(
    parameter int DW        = 8,
    parameter int OVS       = 16,
    parameter int STOP_BITS = 2,
    parameter int SYNC_LEN  = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bit_tick,
    input  logic          parity_en,
    input  logic [DW-1:0] tx_data,
    input  logic          tx_wr,
    output logic          txd,
    output logic          tx_busy,
    output logic          tx_irq,
    input  logic          rxd,
    output logic [DW-1:0] rx_data,
    output logic          rx_ferr,
    output logic          rx_irq
);
    logic rxd_sync;

    sio_tx #(.DW(DW), .OVS(OVS), .STOP_BITS(STOP_BITS)) u_tx (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (bit_tick),
        .parity_en (parity_en),
        .wr_data   (tx_data),
        .wr        (tx_wr),
        .txd       (txd),
        .busy      (tx_busy),
        .irq       (tx_irq)
    );

    sio_sync #(.STAGES(SYNC_LEN)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async (rxd),
        .d_sync  (rxd_sync)
    );

    sio_rx #(.DW(DW), .OVS(OVS)) u_rx (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (bit_tick),
        .parity_en (parity_en),
        .line      (rxd_sync),
        .data      (rx_data),
        .ferr      (rx_ferr),
        .irq       (rx_irq)
    );
endmodule

// File: tb/sio_core_tb.sv
// Bench for sio_core: loopback sweep of all bytes in both parity modes,
// direct receive sweep of the parity flag, and hand-built line patterns.
module sio_core_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bit_tick = 1'b0;
    logic       parity_en = 1'b0;
    logic [7:0] tx_data = 8'h00;
    logic       tx_wr = 1'b0;
    logic       txd, tx_busy, tx_irq, rx_ferr, rx_irq;
    logic [7:0] rx_data;
    logic       loop_en = 1'b1;
    logic       drv_rxd = 1'b1;
    logic       rxd;

    int checks = 0;
    int errors = 0;
    int tick_div = 1;
    int div_cnt = 0;
    int rx_n = 0, tx_n = 0;
    logic [7:0] cap_data = 8'h00, prev_data = 8'h00;
    logic       cap_ferr = 1'b0;
    bit         done = 1'b0;

    assign rxd = loop_en ? txd : drv_rxd;

    sio_core u_dut (
        .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .parity_en(parity_en),
        .tx_data(tx_data), .tx_wr(tx_wr), .txd(txd), .tx_busy(tx_busy),
        .tx_irq(tx_irq), .rxd(rxd), .rx_data(rx_data), .rx_ferr(rx_ferr),
        .rx_irq(rx_irq)
    );

    always #10 clk = ~clk;

    // Tick source: one pulse every tick_div cycles.
    always @(posedge clk) begin
        if (div_cnt >= tick_div - 1) begin
            bit_tick <= 1'b1;
            div_cnt  <= 0;
        end else begin
            bit_tick <= 1'b0;
            div_cnt  <= div_cnt + 1;
        end
    end

    // Interrupt monitors.
    always @(negedge clk) begin
        if (rst_n && rx_irq) begin
            rx_n      <= rx_n + 1;
            prev_data <= cap_data;
            cap_data  <= rx_data;
            cap_ferr  <= rx_ferr;
        end
        if (rst_n && tx_irq) tx_n <= tx_n + 1;
    end

    task automatic chk(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Wait for n ticks as seen by the design; clears the write strobe.
    task automatic wait_ticks(int n);
        while (n > 0) begin
            logic c;
            c = bit_tick;
            @(negedge clk);
            tx_wr = 1'b0;
            if (c) n--;
        end
    endtask

    // Send one byte through the transmitter and check line, timing and loopback.
    task automatic tx_frame(logic [7:0] b, logic pe, bit poke);
        logic [10:0] got;
        logic [10:0] exp;
        logic [7:0]  slots;
        logic [7:0]  rx_exp;
        int rx0, tx0;
        slots  = pe ? {~(^b[6:0]), b[6:0]} : b;
        exp    = {2'b11, slots, 1'b0};
        rx_exp = pe ? {1'b0, b[6:0]} : b;
        rx0 = rx_n; tx0 = tx_n;
        parity_en = pe;
        tx_data = b;
        tx_wr = 1'b1;
        @(negedge clk);
        tx_wr = 1'b0;
        chk(tx_busy == 1'b1, "R4 busy after write", tx_busy, 1);
        wait_ticks(8);
        for (int i = 0; i < 11; i++) begin
            got[i] = txd;
            if (poke && i == 2) begin
                tx_data = ~b;
                tx_wr = 1'b1;
            end
            if (i < 10) wait_ticks(16);
        end
        chk(got == exp, poke ? "R5 frame kept" : "R2 R3 frame", got, exp);
        wait_ticks(8);
        chk(tx_irq && !tx_busy, "R4 irq at tick 176", {tx_irq, tx_busy}, 2'b10);
        @(negedge clk);
        chk(!tx_irq, "R4 irq one cycle", tx_irq, 0);
        @(negedge clk);
        chk(tx_n == tx0 + 1, "R4 one irq", tx_n - tx0, 1);
        chk(rx_n == rx0 + 1 && cap_data == rx_exp && !cap_ferr,
            "R6 loopback byte", {rx_n - rx0, cap_data}, {32'd1, rx_exp});
    endtask

    // Drive one frame onto the receive line with a single stop bit.
    task automatic rx_send(logic [7:0] b, logic stop_val);
        drv_rxd = 1'b0;
        wait_ticks(16);
        for (int i = 0; i < 8; i++) begin
            drv_rxd = b[i];
            wait_ticks(16);
        end
        drv_rxd = stop_val;
        wait_ticks(16);
        drv_rxd = 1'b1;
    endtask

    initial begin : watchdog
        repeat (195000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin : main
        int r0;
        logic [7:0] e;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(txd && !tx_busy && !tx_irq && !rx_irq && !rx_ferr && rx_data == 8'h00,
            "R1 reset state", {txd, tx_busy, tx_irq, rx_irq, rx_ferr, rx_data}, 13'h1000);

        // R2 R3 R6: loopback sweep, both parity modes
        for (int pe = 0; pe < 2; pe++)
            for (int b = 0; b < 256; b++)
                tx_frame(8'(b), pe[0], 1'b0);

        // R5: write during busy, then line stays idle
        tx_frame(8'h5A, 1'b0, 1'b1);
        r0 = tx_n;
        repeat (400) @(negedge clk);
        chk(txd && !tx_busy && tx_n == r0, "R5 no extra frame", {txd, tx_busy}, 2'b10);

        // Slower tick: timing still tracks the tick
        tick_div = 3;
        repeat (4) @(negedge clk);
        tx_frame(8'hC3, 1'b1, 1'b0);
        tx_frame(8'h81, 1'b0, 1'b0);

        // R8: direct receive sweep of the parity flag
        loop_en = 1'b0;
        tick_div = 1;
        parity_en = 1'b1;
        for (int b = 0; b < 256; b++) begin
            r0 = rx_n;
            e = {~(^b[7:0]), b[6:0]};
            rx_send(8'(b), 1'b1);
            wait_ticks(4);
            chk(rx_n == r0 + 1 && cap_data == e, "R8 parity flag", cap_data, e);
        end

        // R7: back-to-back frames with one stop bit each, slower tick
        parity_en = 1'b0;
        tick_div = 2;
        r0 = rx_n;
        rx_send(8'hA5, 1'b1);
        rx_send(8'h3C, 1'b1);
        wait_ticks(8);
        chk(rx_n == r0 + 2 && prev_data == 8'hA5 && cap_data == 8'h3C,
            "R7 single stop back-to-back", {prev_data, cap_data}, 16'hA53C);

        // R9: framing error then recovery
        r0 = rx_n;
        rx_send(8'h96, 1'b0);
        wait_ticks(20);
        chk(rx_n == r0 + 1 && cap_data == 8'h96 && cap_ferr,
            "R9 framing error delivered", {cap_ferr, cap_data}, 9'h196);
        rx_send(8'h17, 1'b1);
        wait_ticks(8);
        chk(rx_n == r0 + 2 && cap_data == 8'h17 && !cap_ferr && !rx_ferr,
            "R9 framing error cleared", {rx_ferr, cap_data}, 9'h017);

        // R10: short low glitch is not a start bit
        r0 = rx_n;
        drv_rxd = 1'b0;
        wait_ticks(4);
        drv_rxd = 1'b1;
        wait_ticks(200);
        chk(rx_n == r0 && rx_data == 8'h17, "R10 glitch rejected", rx_n - r0, 0);

        // R8: parity off keeps bit 7 as received
        tick_div = 1;
        r0 = rx_n;
        rx_send(8'h83, 1'b1);
        wait_ticks(4);
        chk(cap_data == 8'h83, "R8 parity off raw", cap_data, 8'h83);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule